// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This peripheral guards a system against software that stops running. Once it is enabled it counts coarse ticks: each tick is a fixed base number of system clock cycles, and a 2-bit prescale field stretches it by 1, 2, 4 or 8. The first timeout phase runs for a programmable number of ticks. When it ends, the block latches a first interrupt and a second phase begins at once. If software does not kick the timer before the second phase also ends, the block latches a second interrupt and pulses a reset request. A 2-bit code travels with that pulse and tells the external reset logic which kind of reset to perform. After that pulse the block continues counting from the start of phase one.

Software controls the block through a small synchronous register port. Writes are taken on the clock edge at which `reg_wr` is high. Reads are combinational from `reg_addr`. After phase one has expired once, software can no longer switch the block off. Only a reset of the block releases that lock.

Word addresses:
- 0 is control.
- 1 holds the two phase limits.
- 2 is the kick register. Writing any value to it is a kick.
- 3 is status.

A parameter sets the base divider. Its default is 2<<25 cycles, and benches shorten it.

Top module: `wdt_two_phase`

## Requirements
- R1: After reset every register reads 0, and `irq_phase1`, `irq_phase2` and `rst_req` are low.
- R2: One tick lasts BASE_DIV × 2^P clock cycles. P is control bits [2:1].
- R3: Control bit 0 enables the block. Take the edge that takes the enabling write, or the latest kick, as the start. Phase one expires (L1+1) ticks after that start. At expiry, status bit 0 and `irq_phase1` go high after that same edge. L1 is limit bits [PHASE_W-1:0].
- R4: Phase two starts at the expiry edge of phase one. It expires (L2+1) ticks later. At that edge status bit 1 and `irq_phase2` go high, and `rst_req` is high for exactly one cycle. Counting then restarts in phase one. L2 is limit bits [2*PHASE_W-1:PHASE_W].
- R5: `rst_kind` is valid while `rst_req` is high, and it is taken from control bits [4:3]. Code 0 means full chip, 1 means processor only, and 2 means a software-visible reset. The reserved code 3 is sent as 0.
- R6: Status bit 2 is the lock flag, and phase one's expiry sets it. While it is set, a write of control bit 0 = 0 leaves the enable at 1. Before the lock is set, clearing the enable stops the block, and no interrupt or reset follows.
- R7: A write to address 2 clears the tick divider and the phase counter. When it happens during phase two, it returns the block to phase one. Status bit 3 reads 1 only in phase two.
- R8: Writing 1 to status bit 0 or bit 1 clears that interrupt. Writing 0 to a bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 2*PHASE_W | Write data |
| reg_rdata | output | 2*PHASE_W | Read data, combinational from `reg_addr` |
| irq_phase1 | output | 1 | Latched phase-one interrupt |
| irq_phase2 | output | 1 | Latched phase-two interrupt |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Reset kind that goes with `rst_req` |

## Verification
Every timed result is counted from the edge that takes the enabling write or the kick; call that edge E. The phase-one interrupt is visible after edge E+(L1+1)·D·S. The phase-two interrupt and the reset pulse are visible after edge E+(L1+L2+2)·D·S. Here D is the base divider and S is 2^P, and the block adds no pipeline stage beyond the status register. The driver records E from a free-running edge counter and queues each event with its exact edge number. The monitor samples on falling edges and checks each rise and each pulse against the head of the queue. An event that arrives early, late, or not at all is reported. Register effects such as the lock, the W1C clears and the phase flag are read back one cycle after the write edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_LIMIT = 2'd1,
        ADDR_KICK  = 2'd2,
        ADDR_STAT  = 2'd3
    } wdt_addr_e;

    typedef enum logic [1:0] {
        KIND_CHIP = 2'd0,
        KIND_CPU  = 2'd1,
        KIND_SOFT = 2'd2,
        KIND_RSVD = 2'd3
    } wdt_kind_e;

    function automatic logic [1:0] map_kind(input logic [1:0] code);
        return (code == KIND_RSVD) ? KIND_CHIP : code;
    endfunction
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int BASE_DIV = 2 << 25,
    parameter int PRESC_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               clear,
    input  logic [PRESC_W-1:0] prescale,
    output logic               tick
);
    localparam int CNT_W  = (BASE_DIV > 2) ? $clog2(BASE_DIV) : 1;
    localparam int PRE_CW = (1 << PRESC_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0]  base;
        logic [PRE_CW-1:0] pre;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic [PRE_CW:0]   one_sh;
    logic [PRE_CW-1:0] scale_m1;
    logic              base_hit;
    logic              pre_done;

    always_comb begin
        st_d     = st_q;
        one_sh   = (PRE_CW + 1)'(1) << prescale;
        scale_m1 = PRE_CW'(one_sh - (PRE_CW + 1)'(1));
        base_hit = (st_q.base == CNT_W'(BASE_DIV - 1));
        pre_done = (st_q.pre >= scale_m1);
        tick     = run && !clear && base_hit && pre_done;
        if (!run || clear) begin
            st_d = '0;
        end else if (base_hit) begin
            st_d.base = '0;
            st_d.pre  = pre_done ? '0 : st_q.pre + 1'b1;
        end else begin
            st_d.base = st_q.base + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdt_phase_ctr.sv
module wdt_phase_ctr #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               kick,
    input  logic               tick,
    input  logic [PHASE_W-1:0] limit1,
    input  logic [PHASE_W-1:0] limit2,
    output logic               phase_two,
    output logic               p1_exp,
    output logic               p2_exp
);
    typedef struct packed {
        logic               two;
        logic [PHASE_W-1:0] cnt;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic      at_limit;

    always_comb begin
        st_d     = st_q;
        at_limit = st_q.two ? (st_q.cnt == limit2) : (st_q.cnt == limit1);
        p1_exp   = run && !kick && tick && !st_q.two && at_limit;
        p2_exp   = run && !kick && tick &&  st_q.two && at_limit;
        if (!run || kick) begin
            st_d = '0;
        end else if (tick) begin
            if (at_limit) begin
                st_d.two = !st_q.two;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    assign phase_two = st_q.two;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdt_two_phase.sv
module wdt_two_phase
    import wdt_pkg::*;
#(
    parameter int BASE_DIV = 2 << 25,
    parameter int PRESC_W  = 2,
    parameter int PHASE_W  = 8,
    parameter int REG_W    = 2 * PHASE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_phase1,
    output logic             irq_phase2,
    output logic             rst_req,
    output logic [1:0]       rst_kind
);
    localparam int MODE_LO = PRESC_W + 1;
    localparam int MODE_HI = PRESC_W + 2;

    typedef struct packed {
        logic               en;
        logic [PRESC_W-1:0] presc;
        logic [1:0]         mode;
        logic [PHASE_W-1:0] lim1;
        logic [PHASE_W-1:0] lim2;
        logic               stat1;
        logic               stat2;
        logic               lock;
        logic               rst_req;
        logic [1:0]         rst_kind;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       kick;
    logic       tick;
    logic       phase_two;
    logic       p1_exp;
    logic       p2_exp;

    assign kick = reg_wr && (reg_addr == ADDR_KICK);

    wdt_tick_gen #(
        .BASE_DIV (BASE_DIV),
        .PRESC_W  (PRESC_W)
    ) i_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.en),
        .clear    (kick),
        .prescale (st_q.presc),
        .tick     (tick)
    );

    wdt_phase_ctr #(
        .PHASE_W (PHASE_W)
    ) i_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st_q.en),
        .kick      (kick),
        .tick      (tick),
        .limit1    (st_q.lim1),
        .limit2    (st_q.lim2),
        .phase_two (phase_two),
        .p1_exp    (p1_exp),
        .p2_exp    (p2_exp)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL: begin
                    st_d.en    = reg_wdata[0];
                    st_d.presc = reg_wdata[PRESC_W:1];
                    st_d.mode  = reg_wdata[MODE_HI:MODE_LO];
                end
                ADDR_LIMIT: begin
                    st_d.lim1 = reg_wdata[PHASE_W-1:0];
                    st_d.lim2 = reg_wdata[REG_W-1:PHASE_W];
                end
                ADDR_STAT: begin
                    st_d.stat1 = st_q.stat1 & ~reg_wdata[0];
                    st_d.stat2 = st_q.stat2 & ~reg_wdata[1];
                end
                default: ;
            endcase
        end
        if (p1_exp) begin
            st_d.stat1 = 1'b1;
            st_d.lock  = 1'b1;
        end
        if (st_d.lock) begin
            st_d.en = 1'b1;
        end
        if (p2_exp) begin
            st_d.stat2    = 1'b1;
            st_d.rst_req  = 1'b1;
            st_d.rst_kind = map_kind(st_q.mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[0]               = st_q.en;
                reg_rdata[PRESC_W:1]       = st_q.presc;
                reg_rdata[MODE_HI:MODE_LO] = st_q.mode;
            end
            ADDR_LIMIT: reg_rdata = {st_q.lim2, st_q.lim1};
            ADDR_STAT:  reg_rdata[3:0] = {phase_two, st_q.lock, st_q.stat2, st_q.stat1};
            default: ;
        endcase
    end

    assign irq_phase1 = st_q.stat1;
    assign irq_phase2 = st_q.stat2;
    assign rst_req    = st_q.rst_req;
    assign rst_kind   = st_q.rst_kind;
endmodule

// File: rtl/wdt_two_phase_chk.sv
module wdt_two_phase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq1,
    input logic       irq2,
    input logic       rst_req,
    input logic [1:0] rst_kind,
    input logic       phase_two,
    input logic       en,
    input logic       lock,
    input logic       kick,
    input logic       p1_exp,
    input logic       stat_clr1
);
    // R3: the phase-one interrupt rises exactly when phase two begins
    assert_irq1_enters_phase_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq1) |-> phase_two);

    // R4: the reset request lasts a single cycle
    assert_rst_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4: the reset request comes with the phase-two interrupt
    assert_rst_with_irq2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> irq2);

    // R5: the reserved kind code never reaches the output
    assert_kind_not_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (rst_kind != 2'd3));

    // R6: the lock is sticky and keeps the block enabled
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);
    assert_lock_keeps_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> en);

    // R7: a kick returns the block to phase one
    assert_kick_phase_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !phase_two);

    // R8: a write of 1 to status bit 0 clears it unless an expiry coincides
    assert_w1c_irq1_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr1 && !p1_exp) |=> !irq1);
endmodule

bind wdt_two_phase wdt_two_phase_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq1      (irq_phase1),
    .irq2      (irq_phase2),
    .rst_req   (rst_req),
    .rst_kind  (rst_kind),
    .phase_two (phase_two),
    .en        (st_q.en),
    .lock      (st_q.lock),
    .kick      (kick),
    .p1_exp    (p1_exp),
    .stat_clr1 (reg_wr && (reg_addr == 2'd3) && reg_wdata[0])
);

// File: tb/test_wdt_two_phase.sv
`timescale 1ns/1ps
module test_wdt_two_phase;
    localparam int D       = 8;
    localparam int PHASE_W = 8;
    localparam int REG_W   = 2 * PHASE_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             irq_phase1, irq_phase2, rst_req;
    logic [1:0]       rst_kind;

    wdt_two_phase #(.BASE_DIV(D), .PRESC_W(2), .PHASE_W(PHASE_W)) i_wdt_two_phase (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_phase1(irq_phase1),
        .irq_phase2(irq_phase2), .rst_req(rst_req), .rst_kind(rst_kind)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    kind;   // 0 phase-one irq, 1 phase-two irq, 2 reset pulse
        int    at;
        int    rk;
        string req;
    } exp_t;
    exp_t sb[$];

    task automatic push(input int kind, input int at, input int rk, input string req);
        exp_t it;
        it.kind = kind; it.at = at; it.rk = rk; it.req = req;
        sb.push_back(it);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    // monitor: compares observed events with the head of the scoreboard
    logic p1_prev = 1'b0, p2_prev = 1'b0;
    task automatic observe(input int kind);
        exp_t it;
        if (sb.size() == 0) begin
            check(1'b0, (kind == 0) ? "R3/R6" : "R4/R6", "unexpected event kind", kind, -1);
        end else begin
            it = sb.pop_front();
            check(it.kind == kind, it.req, "event kind", kind, it.kind);
            check(it.at == cyc, it.req, "event cycle", cyc, it.at);
            if (kind == 2) check(int'(rst_kind) == it.rk, "R5", "reset kind", int'(rst_kind), it.rk);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            p1_prev <= 1'b0;
            p2_prev <= 1'b0;
        end else begin
            while (sb.size() > 0 && sb[0].at < cyc) begin
                check(1'b0, sb[0].req, "missed event at cycle", cyc, sb[0].at);
                void'(sb.pop_front());
            end
            if (irq_phase1 && !p1_prev) observe(0);
            if (irq_phase2 && !p2_prev) observe(1);
            if (rst_req) observe(2);
            p1_prev <= irq_phase1;
            p2_prev <= irq_phase2;
        end
    end

    // driver tasks
    task automatic wr_reg(input logic [1:0] a, input logic [REG_W-1:0] d, output int e);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        e = cyc;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int expv, input string req, input string what);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(int'(reg_rdata) == expv, req, what, int'(reg_rdata), expv);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [REG_W-1:0] ctrl(input int en, input int p, input int m);
        return REG_W'(en | (p << 1) | (m << 3));
    endfunction

    function automatic logic [REG_W-1:0] lims(input int l1, input int l2);
        return REG_W'(l1 | (l2 << PHASE_W));
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int e, k, dummy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(2'd0, 0, "R1", "control after reset");
        rd_chk(2'd1, 0, "R1", "limits after reset");
        rd_chk(2'd3, 0, "R1", "status after reset");
        check(!irq_phase1 && !irq_phase2 && !rst_req, "R1", "outputs after reset",
              int'({irq_phase1, irq_phase2, rst_req}), 0);

        // A: x1, L1=2, L2=1, kind 1; lock test R6, W1C R8
        wr_reg(2'd1, lims(2, 1), dummy);
        wr_reg(2'd0, ctrl(1, 0, 1), e);
        push(0, e + 24, 0, "R3");
        push(1, e + 40, 0, "R4");
        push(2, e + 40, 1, "R4");
        wait_until(e + 30);
        wr_reg(2'd0, ctrl(0, 0, 1), dummy);
        rd_chk(2'd0, 9, "R6", "control after locked disable");
        rd_chk(2'd3, 13, "R6", "status lock and phase two");
        wait_until(e + 42);
        wr_reg(2'd3, REG_W'(1), dummy);
        rd_chk(2'd3, 6, "R8", "status after clearing bit 0 only");
        do_reset();

        // B: x4 prescale (R2), L1=0, L2=0, reserved kind 3 -> 0 (R5)
        wr_reg(2'd1, lims(0, 0), dummy);
        wr_reg(2'd0, ctrl(1, 2, 3), e);
        push(0, e + 32, 0, "R2");
        push(1, e + 64, 0, "R2");
        push(2, e + 64, 0, "R5");
        wait_until(e + 66);
        do_reset();

        // C: x2 prescale, L1=3, L2=0, kind 2; kick in phase one (R7)
        wr_reg(2'd1, lims(3, 0), dummy);
        wr_reg(2'd0, ctrl(1, 1, 2), e);
        wait_until(e + 40);
        wr_reg(2'd2, '0, k);
        push(0, k + 64, 0, "R7");
        push(1, k + 80, 0, "R7");
        push(2, k + 80, 2, "R5");
        wait_until(k + 82);
        do_reset();

        // D: disable before phase one expires (R6)
        wr_reg(2'd1, lims(1, 0), dummy);
        wr_reg(2'd0, ctrl(1, 0, 0), e);
        wait_until(e + 8);
        wr_reg(2'd0, ctrl(0, 0, 0), dummy);
        rd_chk(2'd0, 0, "R6", "control after unlocked disable");
        wait_until(e + 60);
        rd_chk(2'd3, 0, "R6", "status after stopped run");
        check(!irq_phase1 && !rst_req, "R6", "outputs after stopped run",
              int'({irq_phase1, rst_req}), 0);
        do_reset();

        // E: kick in phase two returns to phase one (R7), W1C (R8)
        wr_reg(2'd1, lims(1, 3), dummy);
        wr_reg(2'd0, ctrl(1, 0, 0), e);
        push(0, e + 16, 0, "R3");
        wait_until(e + 20);
        rd_chk(2'd3, 13, "R7", "status in phase two");
        wr_reg(2'd3, REG_W'(1), dummy);
        check(!irq_phase1, "R8", "irq_phase1 after write 1", int'(irq_phase1), 0);
        wait_until(e + 30);
        wr_reg(2'd2, '0, k);
        rd_chk(2'd3, 4, "R7", "status after kick in phase two");
        push(0, k + 16, 0, "R7");
        push(1, k + 48, 0, "R4");
        push(2, k + 48, 0, "R5");
        wait_until(k + 52);

        check(sb.size() == 0, "R4", "pending scoreboard items", sb.size(), 0);
        finish_run();
    end
endmodule